// File: doc/BRIEF.md
# Inter-Processor Interrupt Destination Router

This block takes the two command words that a processor writes to launch an inter-processor interrupt and decides which of `NUM_CPU` processors receive it. The high word carries an 8-bit destination; the low word carries the vector, delivery mode, destination mode, level, trigger and a two-bit shorthand. Writing the low word launches the interrupt. One clock later the block presents a one-cycle `ipi_valid_o` pulse together with a per-processor accept mask and the decoded vector, delivery mode, trigger and level.

Each processor supplies its physical ID, its 8-bit logical ID and an enable bit. The block keeps a destination-format register for each processor. Its top nibble selects flat logical matching when it is `4'hF` and cluster matching for any other value. For lowest-priority delivery the block picks exactly one enabled matching processor by rotation. It keeps a separate rotation pointer for every vector value.

Top module: `ipi_dest_router`

## Requirements
- R1: A low-word write is decoded as follows: vector in bits 7:0, delivery mode in bits 10:8, logical destination mode in bit 11, level in bit 14, trigger in bit 15 and shorthand in bits 19:18. The decoded fields appear on the outputs one cycle after the write.
- R2: A high-word write keeps only bits 31:24, which form the destination. Bits 23:0 read back as zero.
- R3: The low word reads back as written, except that bit 12 is always zero. Each low-word write produces exactly one `ipi_valid_o` pulse, in the following cycle.
- R4: The shorthand selects the targets. A value of 1 targets only the sender, 2 targets every processor, and 3 targets every processor except the sender. A value of 0 uses the destination field.
- R5: With shorthand 0 and bit 11 clear (physical mode), a processor matches when its physical ID equals the destination.
- R6: With shorthand 0 and bit 11 set, a processor whose format register has top nibble `4'hF` (flat) matches when its logical ID ANDed with the destination is nonzero.
- R7: With shorthand 0 and bit 11 set, a processor in cluster format matches when the upper nibble of its logical ID equals the upper nibble of the destination and the lower nibbles ANDed together are nonzero.
- R8: The format registers reset to `32'hFFFF_FFFF`. A write stores the data with bits 27:0 forced to ones.
- R9: Delivery mode `3'b001` (lowest priority) grants exactly one processor. The grant goes to the first matching enabled processor found when searching upward from the one after that vector's pointer, wrapping at the end. The pointer then becomes the chosen index. Pointers are independent per vector and reset to `NUM_CPU-1`, so the first search starts at processor 0.
- R10: If no matching enabled processor exists for a lowest-priority interrupt, the mask is zero and that vector's pointer is unchanged.
- R11: A lowest-priority interrupt with shorthand 0, logical mode and destination `8'hFF`, issued while any processor is in cluster format, raises `bcast_err_o`. In that case nothing is delivered and the pointer is unchanged. The flag clears on the next launch that lacks this condition.
- R12: For every delivery mode other than lowest priority, the accept mask equals the match set, whatever the enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_lo_wr | input | 1 | Low-word write strobe; launches an interrupt |
| cmd_lo_wdata | input | 32 | Low-word write data |
| cmd_hi_wr | input | 1 | High-word write strobe |
| cmd_hi_wdata | input | 32 | High-word write data |
| sender_i | input | IDX_W | Index of the processor issuing the write |
| apic_id_i | input | NUM_CPU*8 | Physical ID of each processor |
| logical_id_i | input | NUM_CPU*8 | Logical ID of each processor |
| cpu_en_i | input | NUM_CPU | Enable state of each processor |
| fmt_wr_i | input | NUM_CPU | Per-processor format-register write strobe |
| fmt_wdata_i | input | 32 | Format-register write data |
| cmd_lo_rd_o | output | 32 | Stored low word |
| cmd_hi_rd_o | output | 32 | Stored high word |
| fmt_rd_o | output | NUM_CPU*32 | Format registers |
| ipi_valid_o | output | 1 | One-cycle launch pulse |
| accept_mask_o | output | NUM_CPU | Processors receiving the interrupt |
| vector_o | output | 8 | Decoded vector |
| dlv_mode_o | output | 3 | Decoded delivery mode |
| trig_o | output | 1 | Decoded trigger mode |
| level_o | output | 1 | Decoded level |
| bcast_err_o | output | 1 | Cluster broadcast error flag |

## Verification
Every result of this block passes through one register. After the clock edge that takes a low-word write, the mask, fields, error flag, readbacks and pulse are all due, and a high-word or format write is visible one edge after it is taken. The bench drives every strobe for exactly one cycle, starting at a falling edge. It samples at the very next falling edge, and checks that the pulse is gone one cycle later. Because pointer effects only show up through later grants, the lowest-priority checks are chained in a fixed order, and each expected grant is computed from the rotation rule.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int WORD_W = 32;
    localparam int ID_W   = 8;
    localparam int FMT_W  = 4;

    localparam logic [2:0]        DLV_LOWEST  = 3'b001;
    localparam logic [FMT_W-1:0]  FMT_FLAT    = 4'hF;
    localparam logic [ID_W-1:0]   DEST_BCAST  = 8'hFF;
    localparam int                STATUS_BIT  = 12;

    typedef enum logic [1:0] {
        SH_DEST   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } shorthand_e;

    typedef struct packed {
        logic [7:0] vector;
        logic [2:0] mode;
        logic       logical;
        logic       level;
        logic       trig;
        shorthand_e shorthand;
    } ipi_cmd_t;

    function automatic ipi_cmd_t decode_cmd(input logic [WORD_W-1:0] w);
        ipi_cmd_t c;
        c.vector    = w[7:0];
        c.mode      = w[10:8];
        c.logical   = w[11];
        c.level     = w[14];
        c.trig      = w[15];
        c.shorthand = shorthand_e'(w[19:18]);
        return c;
    endfunction

endpackage

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
    import ipi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int IDX_W   = 2
) (
    input  ipi_cmd_t                     cmd_i,
    input  logic [ID_W-1:0]              dest_i,
    input  logic [IDX_W-1:0]             sender_i,
    input  logic [NUM_CPU*ID_W-1:0]      apic_id_i,
    input  logic [NUM_CPU*ID_W-1:0]      logical_id_i,
    input  logic [NUM_CPU*FMT_W-1:0]     fmt_i,
    output logic [NUM_CPU-1:0]           match_o,
    output logic                         cluster_bcast_o
);

    logic [NUM_CPU-1:0] is_cluster;

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
        logic [ID_W-1:0]  phys_id;
        logic [ID_W-1:0]  log_id;
        logic             is_self;
        logic             logical_hit;

        assign phys_id       = apic_id_i[g*ID_W +: ID_W];
        assign log_id        = logical_id_i[g*ID_W +: ID_W];
        assign is_self       = (sender_i == IDX_W'(g));
        assign is_cluster[g] = (fmt_i[g*FMT_W +: FMT_W] != FMT_FLAT);

        always_comb begin
            if (is_cluster[g]) begin
                logical_hit = (log_id[7:4] == dest_i[7:4]) &&
                              ((log_id[3:0] & dest_i[3:0]) != 4'h0);
            end else begin
                logical_hit = ((log_id & dest_i) != '0);
            end
        end

        always_comb begin
            unique case (cmd_i.shorthand)
                SH_DEST:   match_o[g] = cmd_i.logical ? logical_hit
                                                      : (phys_id == dest_i);
                SH_SELF:   match_o[g] = is_self;
                SH_ALL:    match_o[g] = 1'b1;
                SH_OTHERS: match_o[g] = !is_self;
                default:   match_o[g] = 1'b0;
            endcase
        end
    end

    assign cluster_bcast_o = (cmd_i.mode == DLV_LOWEST) &&
                             (cmd_i.shorthand == SH_DEST) &&
                             cmd_i.logical &&
                             (dest_i == DEST_BCAST) &&
                             (|is_cluster);

endmodule

// File: rtl/ipi_fmt_bank.sv
module ipi_fmt_bank
    import ipi_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CPU-1:0]         wr_i,
    input  logic [WORD_W-1:0]          wdata_i,
    output logic [NUM_CPU*WORD_W-1:0]  fmt_word_o,
    output logic [NUM_CPU*FMT_W-1:0]   fmt_sel_o
);

    localparam logic [WORD_W-1:0] FORCE_ONES = {{FMT_W{1'b0}}, {(WORD_W-FMT_W){1'b1}}};
    localparam logic [WORD_W-1:0] RESET_VAL  = '1;

    logic [WORD_W-1:0] fmt_d [NUM_CPU];
    logic [WORD_W-1:0] fmt_q [NUM_CPU];

    always_comb begin
        for (int i = 0; i < NUM_CPU; i++) begin
            fmt_d[i] = wr_i[i] ? (wdata_i | FORCE_ONES) : fmt_q[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CPU; i++) begin
            fmt_q[i] <= rst_n ? fmt_d[i] : RESET_VAL;
        end
    end

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_out
        assign fmt_word_o[g*WORD_W +: WORD_W] = fmt_q[g];
        assign fmt_sel_o[g*FMT_W +: FMT_W]    = fmt_q[g][WORD_W-1 -: FMT_W];

        AST_FMT_LOW_ONES: assert property (@(posedge clk) disable iff (!rst_n)
            wr_i[g] |=> (fmt_q[g][WORD_W-FMT_W-1:0] == '1)) else $error("fmt bits"); // R8
    end

endmodule

// File: rtl/ipi_rr_arbiter.sv
module ipi_rr_arbiter #(
    parameter int NUM_CPU = 4,
    parameter int IDX_W   = 2,
    parameter int NUM_VEC = 256,
    parameter int VEC_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    input  logic [VEC_W-1:0]     vector_i,
    input  logic [NUM_CPU-1:0]   cand_i,
    output logic [NUM_CPU-1:0]   grant_o
);

    localparam logic [IDX_W-1:0] PTR_RESET = IDX_W'(NUM_CPU - 1);

    logic [IDX_W-1:0] ptr_d [NUM_VEC];
    logic [IDX_W-1:0] ptr_q [NUM_VEC];
    logic [IDX_W-1:0] start;
    logic [IDX_W-1:0] pick;
    logic             found;

    assign start = ptr_q[vector_i];

    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int k = 1; k <= NUM_CPU; k++) begin
            int idx;
            idx = int'(start) + k;
            if (idx >= NUM_CPU) idx = idx - NUM_CPU;
            if (!found && cand_i[idx]) begin
                found = 1'b1;
                pick  = IDX_W'(idx);
            end
        end
    end

    always_comb begin
        grant_o = '0;
        if (found) grant_o[pick] = 1'b1;
    end

    always_comb begin
        for (int v = 0; v < NUM_VEC; v++) ptr_d[v] = ptr_q[v];
        if (req_i && found) ptr_d[vector_i] = pick;
    end

    always_ff @(posedge clk) begin
        for (int v = 0; v < NUM_VEC; v++) begin
            ptr_q[v] <= rst_n ? ptr_d[v] : PTR_RESET;
        end
    end

    AST_GRANT_WHEN_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && (cand_i != '0)) |-> ((grant_o & cand_i) != '0)) else $error("no grant"); // R9

endmodule

// File: rtl/ipi_dest_router.sv
module ipi_dest_router
    import ipi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int IDX_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_lo_wr,
    input  logic [31:0]                cmd_lo_wdata,
    input  logic                       cmd_hi_wr,
    input  logic [31:0]                cmd_hi_wdata,
    input  logic [IDX_W-1:0]           sender_i,
    input  logic [NUM_CPU*8-1:0]       apic_id_i,
    input  logic [NUM_CPU*8-1:0]       logical_id_i,
    input  logic [NUM_CPU-1:0]         cpu_en_i,
    input  logic [NUM_CPU-1:0]         fmt_wr_i,
    input  logic [31:0]                fmt_wdata_i,
    output logic [31:0]                cmd_lo_rd_o,
    output logic [31:0]                cmd_hi_rd_o,
    output logic [NUM_CPU*32-1:0]      fmt_rd_o,
    output logic                       ipi_valid_o,
    output logic [NUM_CPU-1:0]         accept_mask_o,
    output logic [7:0]                 vector_o,
    output logic [2:0]                 dlv_mode_o,
    output logic                       trig_o,
    output logic                       level_o,
    output logic                       bcast_err_o
);

    localparam int VEC_W   = 8;
    localparam int NUM_VEC = 1 << VEC_W;
    localparam logic [WORD_W-1:0] LO_KEEP = ~(WORD_W'(1) << STATUS_BIT);
    localparam logic [WORD_W-1:0] HI_KEEP = {{ID_W{1'b1}}, {(WORD_W-ID_W){1'b0}}};

    typedef struct packed {
        logic [WORD_W-1:0]  lo;
        logic [WORD_W-1:0]  hi;
        logic [IDX_W-1:0]   sender;
        logic               valid;
        logic [NUM_CPU-1:0] mask;
        ipi_cmd_t           cmd;
        logic               err;
    } state_t;

    state_t st_d, st_q;

    ipi_cmd_t               new_cmd;
    logic [ID_W-1:0]        dest;
    logic [NUM_CPU-1:0]     match;
    logic [NUM_CPU-1:0]     grant;
    logic [NUM_CPU*FMT_W-1:0] fmt_sel;
    logic                   bcast_err;
    logic                   is_lowest;
    logic                   rr_req;

    assign new_cmd   = decode_cmd(cmd_lo_wdata);
    assign dest      = st_q.hi[WORD_W-1 -: ID_W];
    assign is_lowest = (new_cmd.mode == DLV_LOWEST);
    assign rr_req    = cmd_lo_wr && is_lowest && !bcast_err;

    ipi_fmt_bank #(
        .NUM_CPU (NUM_CPU)
    ) i_fmt_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (fmt_wr_i),
        .wdata_i    (fmt_wdata_i),
        .fmt_word_o (fmt_rd_o),
        .fmt_sel_o  (fmt_sel)
    );

    ipi_dest_match #(
        .NUM_CPU (NUM_CPU),
        .IDX_W   (IDX_W)
    ) i_dest_match (
        .cmd_i           (new_cmd),
        .dest_i          (dest),
        .sender_i        (sender_i),
        .apic_id_i       (apic_id_i),
        .logical_id_i    (logical_id_i),
        .fmt_i           (fmt_sel),
        .match_o         (match),
        .cluster_bcast_o (bcast_err)
    );

    ipi_rr_arbiter #(
        .NUM_CPU (NUM_CPU),
        .IDX_W   (IDX_W),
        .NUM_VEC (NUM_VEC),
        .VEC_W   (VEC_W)
    ) i_rr_arbiter (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (rr_req),
        .vector_i (new_cmd.vector),
        .cand_i   (match & cpu_en_i),
        .grant_o  (grant)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (cmd_hi_wr) begin
            st_d.hi = cmd_hi_wdata & HI_KEEP;
        end
        if (cmd_lo_wr) begin
            st_d.lo     = cmd_lo_wdata & LO_KEEP;
            st_d.cmd    = new_cmd;
            st_d.sender = sender_i;
            st_d.valid  = 1'b1;
            st_d.err    = bcast_err;
            if (bcast_err) begin
                st_d.mask = '0;
            end else if (is_lowest) begin
                st_d.mask = grant;
            end else begin
                st_d.mask = match;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_lo_rd_o   = st_q.lo;
    assign cmd_hi_rd_o   = st_q.hi;
    assign ipi_valid_o   = st_q.valid;
    assign accept_mask_o = st_q.mask;
    assign vector_o      = st_q.cmd.vector;
    assign dlv_mode_o    = st_q.cmd.mode;
    assign trig_o        = st_q.cmd.trig;
    assign level_o       = st_q.cmd.level;
    assign bcast_err_o   = st_q.err;

    AST_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_lo_wr |=> ipi_valid_o) else $error("no launch"); // R3

    AST_STATUS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_lo_wr |=> !cmd_lo_rd_o[STATUS_BIT]) else $error("status bit"); // R3

    AST_LOWEST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ipi_valid_o && (dlv_mode_o == DLV_LOWEST)) |-> $onehot0(accept_mask_o)) else $error("multi grant"); // R9

    AST_ERR_NO_DELIVERY: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_err_o |-> (accept_mask_o == '0)) else $error("err delivered"); // R11

    AST_OTHERS_SKIP_SENDER: assert property (@(posedge clk) disable iff (!rst_n)
        (ipi_valid_o && (st_q.cmd.shorthand == SH_OTHERS) && (dlv_mode_o != DLV_LOWEST))
        |-> (accept_mask_o == ~(NUM_CPU'(1) << st_q.sender))) else $error("others"); // R4

endmodule

// File: tb/test_ipi_dest_router.sv
module test_ipi_dest_router;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int IW = 2;

    typedef struct packed {
        logic [31:0] lo;
        logic [31:0] hi;
        logic [3:0]  mask;
    } vec_t;

    localparam int NUM_VEC_ROWS = 9;
    localparam vec_t VEC_TABLE [NUM_VEC_ROWS] = '{
        '{32'h0000_1041, 32'h22AB_CDEF, 4'b0100},   // R5 phys hit, R3 bit12, R2 low bits
        '{32'h0000_0042, 32'h3000_0000, 4'b0000},   // R5 phys miss
        '{32'h0000_0843, 32'h0500_0000, 4'b0101},   // R6 flat
        '{32'h0000_0844, 32'h0F00_0000, 4'b1111},   // R6 flat all
        '{32'h0004_0045, 32'h0000_0000, 4'b0010},   // R4 self
        '{32'h0008_0046, 32'h0000_0000, 4'b1111},   // R4 all
        '{32'h000C_0047, 32'h0000_0000, 4'b1101},   // R4 others
        '{32'h0000_C048, 32'h2300_0000, 4'b1000},   // R1 trigger+level
        '{32'h0000_0449, 32'h2000_0000, 4'b0001}    // R1 mode 4
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_lo_wr = 1'b0;
    logic [31:0]     cmd_lo_wdata = '0;
    logic            cmd_hi_wr = 1'b0;
    logic [31:0]     cmd_hi_wdata = '0;
    logic [IW-1:0]   sender = IW'(1);
    logic [N*8-1:0]  apic_id = {8'h23, 8'h22, 8'h21, 8'h20};
    logic [N*8-1:0]  logical_id = {8'h08, 8'h04, 8'h02, 8'h01};
    logic [N-1:0]    cpu_en = '1;
    logic [N-1:0]    fmt_wr = '0;
    logic [31:0]     fmt_wdata = '0;
    logic [31:0]     cmd_lo_rd, cmd_hi_rd;
    logic [N*32-1:0] fmt_rd;
    logic            ipi_valid;
    logic [N-1:0]    accept_mask;
    logic [7:0]      vector;
    logic [2:0]      dlv_mode;
    logic            trig, level, bcast_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipi_dest_router #(.NUM_CPU(N)) i_ipi_dest_router (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_lo_wr     (cmd_lo_wr),
        .cmd_lo_wdata  (cmd_lo_wdata),
        .cmd_hi_wr     (cmd_hi_wr),
        .cmd_hi_wdata  (cmd_hi_wdata),
        .sender_i      (sender),
        .apic_id_i     (apic_id),
        .logical_id_i  (logical_id),
        .cpu_en_i      (cpu_en),
        .fmt_wr_i      (fmt_wr),
        .fmt_wdata_i   (fmt_wdata),
        .cmd_lo_rd_o   (cmd_lo_rd),
        .cmd_hi_rd_o   (cmd_hi_rd),
        .fmt_rd_o      (fmt_rd),
        .ipi_valid_o   (ipi_valid),
        .accept_mask_o (accept_mask),
        .vector_o      (vector),
        .dlv_mode_o    (dlv_mode),
        .trig_o        (trig),
        .level_o       (level),
        .bcast_err_o   (bcast_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // hi write, then lo write; returns at the falling edge after the launch edge
    task automatic send(input logic [31:0] lo, input logic [31:0] hi);
        @(negedge clk);
        cmd_hi_wr = 1'b1; cmd_hi_wdata = hi;
        @(negedge clk);
        cmd_hi_wr = 1'b0;
        cmd_lo_wr = 1'b1; cmd_lo_wdata = lo;
        @(negedge clk);
        cmd_lo_wr = 1'b0;
    endtask

    task automatic fmt_write(input logic [N-1:0] sel, input logic [31:0] data);
        @(negedge clk);
        fmt_wr = sel; fmt_wdata = data;
        @(negedge clk);
        fmt_wr = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        chk("R3 reset valid", 32'(ipi_valid), 32'h0);
        chk("R3 reset mask", 32'(accept_mask), 32'h0);
        chk("R11 reset err", 32'(bcast_err), 32'h0);
        chk("R8 reset fmt0", fmt_rd[31:0], 32'hFFFF_FFFF);
        chk("R8 reset fmt3", fmt_rd[127:96], 32'hFFFF_FFFF);
        rst_n = 1'b1;

        for (int i = 0; i < NUM_VEC_ROWS; i++) begin
            send(VEC_TABLE[i].lo, VEC_TABLE[i].hi);
            chk("R4/R5/R6 mask", 32'(accept_mask), 32'(VEC_TABLE[i].mask));
            chk("R3 valid", 32'(ipi_valid), 32'h1);
            chk("R1 vector", 32'(vector), 32'(VEC_TABLE[i].lo[7:0]));
            chk("R1 mode", 32'(dlv_mode), 32'(VEC_TABLE[i].lo[10:8]));
            chk("R1 trig", 32'(trig), 32'(VEC_TABLE[i].lo[15]));
            chk("R1 level", 32'(level), 32'(VEC_TABLE[i].lo[14]));
            chk("R3 lo readback", cmd_lo_rd, VEC_TABLE[i].lo & 32'hFFFF_EFFF);
            chk("R2 hi readback", cmd_hi_rd, {VEC_TABLE[i].hi[31:24], 24'h0});
            @(negedge clk);
            chk("R3 single pulse", 32'(ipi_valid), 32'h0);
        end

        // R12: fixed delivery ignores enables
        cpu_en = 4'b1011;
        send(32'h0000_0041, 32'h2200_0000);
        chk("R12 fixed to disabled", 32'(accept_mask), 32'h4);
        cpu_en = 4'b1111;

        // R9: rotation, vector 0x50 broadcast lowest
        send(32'h0008_0150, 32'h0);
        chk("R9 first pick cpu0", 32'(accept_mask), 32'h1);
        send(32'h0008_0150, 32'h0);
        chk("R9 rotate cpu1", 32'(accept_mask), 32'h2);
        send(32'h0008_0150, 32'h0);
        chk("R9 rotate cpu2", 32'(accept_mask), 32'h4);
        cpu_en = 4'b0111;
        send(32'h0008_0150, 32'h0);
        chk("R9 skip disabled wrap", 32'(accept_mask), 32'h1);
        send(32'h0008_0151, 32'h0);
        chk("R9 per-vector pointer", 32'(accept_mask), 32'h1);
        cpu_en = 4'b1111;
        send(32'h0000_0950, 32'h0600_0000);
        chk("R9 logical lowest", 32'(accept_mask), 32'h2);

        // R10: no candidate, pointer unchanged
        cpu_en = 4'b0111;
        send(32'h0000_0150, 32'h2300_0000);
        chk("R10 no candidate", 32'(accept_mask), 32'h0);
        cpu_en = 4'b1111;
        send(32'h0008_0150, 32'h0);
        chk("R10 pointer kept", 32'(accept_mask), 32'h4);

        // R8: format register writes
        fmt_write(4'b0001, 32'h0000_0000);
        chk("R8 forced ones", fmt_rd[31:0], 32'h0FFF_FFFF);
        chk("R8 others untouched", fmt_rd[63:32], 32'hFFFF_FFFF);
        fmt_write(4'b1111, 32'h0000_0000);

        // R7: cluster matching
        logical_id = {8'h24, 8'h21, 8'h12, 8'h11};
        send(32'h0000_0870, 32'h1300_0000);
        chk("R7 cluster 1", 32'(accept_mask), 32'h3);
        send(32'h0000_0870, 32'h2500_0000);
        chk("R7 cluster 2", 32'(accept_mask), 32'hC);
        send(32'h0000_0870, 32'h1200_0000);
        chk("R7 cluster exact", 32'(accept_mask), 32'h2);

        // R11: cluster lowest broadcast error
        send(32'h0000_0960, 32'hFF00_0000);
        chk("R11 err raised", 32'(bcast_err), 32'h1);
        chk("R11 no delivery", 32'(accept_mask), 32'h0);
        send(32'h0008_0160, 32'h0);
        chk("R11 pointer kept", 32'(accept_mask), 32'h1);
        chk("R11 err cleared", 32'(bcast_err), 32'h0);

        // R6: back to flat
        fmt_write(4'b1111, 32'hF000_0000);
        chk("R8 flat readback", fmt_rd[127:96], 32'hFFFF_FFFF);
        logical_id = {8'h08, 8'h04, 8'h02, 8'h01};
        send(32'h0000_0871, 32'h0A00_0000);
        chk("R6 flat again", 32'(accept_mask), 32'hA);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule